// File: doc/BRIEF.md
# Register Hazard Stall Controller

This block is the pipeline-control core of a five-stage in-order processor: decode, then execute, memory and write-back, fed by fetch. It carries the register-ID fields of each instruction through four pipeline registers and compares the two source IDs of the instruction in decode against both destination IDs of every instruction further down the pipe. A match means a read-after-write hazard. No forwarding is available, so the block resolves the hazard by holding decode and fetch and letting a no-op bubble enter execute. It keeps doing this until the producer has retired from write-back.

Instructions enter through a valid/ready port. `in_ready` drops while decode is stalled. A source that sees `in_ready` low must hold `in_valid` and all instruction fields steady until a rising edge where both are high; that edge is the acceptance. A cycle with `in_ready` high and `in_valid` low places a bubble in decode. The write-back side has no back-pressure: every instruction leaving write-back is presented for exactly one cycle. The mode pins (`stall_f`, `stall_d`, `bubble_d`, `bubble_e`) are plain status outputs that a surrounding datapath can use to steer its own pipeline registers in step.

Top module: `hz_stall_ctrl`

## Requirements
- R1: While the instruction in decode has a source ID equal to the ALU-result destination or the memory-result destination of any valid or bubble entry in execute, memory or write-back, `stall_d` is 1; otherwise it is 0.
- R2: Register ID 4'hF means "no register". A source or destination of 4'hF never produces a match, including 4'hF against 4'hF.
- R3: While stalled, `stall_f` and `bubble_e` are 1 and `in_ready` is 0. The decode entry is kept unchanged, and on the next edge execute receives a bubble (`ex_valid` 0). After the stall, the held instruction is the one that moves to execute.
- R4: A consumer issued directly after its producer, or with 1, 2 or 3 idle cycles between them, is stalled for 3, 2, 1 or 0 cycles respectively. It never stalls for more than 3 consecutive cycles.
- R5: Accepted instructions leave write-back in acceptance order, each exactly once. Without stalls, an instruction appears on the `wb_*` outputs after the third rising edge following its acceptance.
- R6: A cycle with `in_ready` 1 and `in_valid` 0 loads a bubble into decode, whatever the instruction fields hold. Those fields then cause no stall and nothing retires from them.
- R7: A bubble holds valid 0, opcode 4'h0 (no-op) and both destination IDs 4'hF. Whenever `wb_valid` is 0, `wb_op` is 4'h0 and `wb_dst_e` and `wb_dst_m` are 4'hF.
- R8: After reset, every stage holds a bubble, `in_ready` is 1 and `stall_d`, `ex_valid` and `wb_valid` are 0.
- R9: No pipeline register is ever told to stall and to take a bubble in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch offers an instruction |
| in_ready | output | 1 | Decode can take the offered instruction |
| in_op | input | 4 | Opcode of offered instruction (4'h0 = no-op) |
| in_src_a | input | 4 | First source register ID (4'hF = none) |
| in_src_b | input | 4 | Second source register ID (4'hF = none) |
| in_dst_e | input | 4 | ALU-result destination ID (4'hF = none) |
| in_dst_m | input | 4 | Memory-result destination ID (4'hF = none) |
| in_tag | input | 8 | Identifier carried with the instruction |
| stall_f | output | 1 | Fetch register mode: hold |
| stall_d | output | 1 | Decode register mode: hold (hazard present) |
| bubble_d | output | 1 | Decode register mode: load bubble |
| bubble_e | output | 1 | Execute register mode: load bubble |
| ex_valid | output | 1 | Execute stage holds a real instruction |
| ex_tag | output | 8 | Tag of instruction in execute |
| wb_valid | output | 1 | Write-back stage holds a real instruction |
| wb_op | output | 4 | Opcode in write-back |
| wb_dst_e | output | 4 | ALU-result destination in write-back |
| wb_dst_m | output | 4 | Memory-result destination in write-back |
| wb_tag | output | 8 | Tag of instruction in write-back |

## Verification
Every cycle, the assertions check the following: the mode signals are consistent and never ask one register to both hold and bubble; a stall always puts a bubble into execute; an idle input slot becomes a decode bubble; a run of stalls never exceeds the pipeline depth; and any empty write-back slot carries the no-op pattern. The exact stall count for each producer–consumer distance, the handling of 4'hF, the in-order exactly-once retirement with its fixed latency, and the fact that the held instruction (not a newer one) reaches execute all depend on instruction sequences. Only the bench's directed scenarios show these, through the tags and cycle stamps seen at write-back.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned OP_W  = 4;
  localparam int unsigned RID_W = 4;
  localparam int unsigned TAG_W = 8;

  localparam logic [RID_W-1:0] RID_NONE = '1;
  localparam logic [OP_W-1:0]  OP_NOP   = '0;

  typedef struct packed {
    logic             valid;
    logic [OP_W-1:0]  op;
    logic [RID_W-1:0] src_a;
    logic [RID_W-1:0] src_b;
    logic [RID_W-1:0] dst_e;
    logic [RID_W-1:0] dst_m;
    logic [TAG_W-1:0] tag;
  } stage_t;

  localparam stage_t STAGE_BUBBLE = '{
    valid: 1'b0,
    op:    OP_NOP,
    src_a: RID_NONE,
    src_b: RID_NONE,
    dst_e: RID_NONE,
    dst_m: RID_NONE,
    tag:   '0
  };
endpackage

// File: rtl/hz_pipe_reg.sv
// Pipeline register with three update modes: load, hold, bubble.
module hz_pipe_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] NOP_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stall,
  input  logic         bubble,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= NOP_VAL;
    else if (bubble) q <= NOP_VAL;
    else if (!stall) q <= d;
  end
endmodule

// File: rtl/hz_detect.sv
// Combinational read-after-write comparison of decode sources
// against the destinations of the N stages behind decode.
module hz_detect import hz_pkg::*; #(
  parameter int unsigned N = 3
) (
  input  logic [RID_W-1:0]        src_a,
  input  logic [RID_W-1:0]        src_b,
  input  logic [N-1:0][RID_W-1:0] dst_e,
  input  logic [N-1:0][RID_W-1:0] dst_m,
  output logic                    hazard
);
  function automatic logic id_hit(input logic [RID_W-1:0] s,
                                  input logic [RID_W-1:0] t);
    return (s != RID_NONE) && (s == t);
  endfunction

  always_comb begin
    hazard = 1'b0;
    for (int i = 0; i < N; i++) begin
      hazard = hazard | id_hit(src_a, dst_e[i]) | id_hit(src_a, dst_m[i])
                      | id_hit(src_b, dst_e[i]) | id_hit(src_b, dst_m[i]);
    end
  end
endmodule

// File: rtl/hz_mode_ctl.sv
// Turns the hazard flag and the input handshake into per-register modes.
// Index 0 is decode, 1 is execute, higher indices follow.
module hz_mode_ctl #(
  parameter int unsigned NSTG = 4
) (
  input  logic            hazard,
  input  logic            in_valid,
  output logic            in_ready,
  output logic            stall_f,
  output logic [NSTG-1:0] stall,
  output logic [NSTG-1:0] bubble
);
  always_comb begin
    stall     = '0;
    bubble    = '0;
    stall[0]  = hazard;
    bubble[0] = !hazard && !in_valid;
    bubble[1] = hazard;
    stall_f   = hazard;
    in_ready  = !hazard;
  end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl import hz_pkg::*; #(
  parameter int unsigned HAZ_STAGES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [RID_W-1:0] in_src_a,
  input  logic [RID_W-1:0] in_src_b,
  input  logic [RID_W-1:0] in_dst_e,
  input  logic [RID_W-1:0] in_dst_m,
  input  logic [TAG_W-1:0] in_tag,
  output logic             stall_f,
  output logic             stall_d,
  output logic             bubble_d,
  output logic             bubble_e,
  output logic             ex_valid,
  output logic [TAG_W-1:0] ex_tag,
  output logic             wb_valid,
  output logic [OP_W-1:0]  wb_op,
  output logic [RID_W-1:0] wb_dst_e,
  output logic [RID_W-1:0] wb_dst_m,
  output logic [TAG_W-1:0] wb_tag
);
  localparam int unsigned NSTG = HAZ_STAGES + 1;
  localparam int unsigned SW   = $bits(stage_t);

  stage_t                         fetch_w;
  stage_t                         stg_d [NSTG];
  stage_t                         stg_q [NSTG];
  logic [NSTG-1:0]                st_stall;
  logic [NSTG-1:0]                st_bubble;
  logic [HAZ_STAGES-1:0][RID_W-1:0] chk_e;
  logic [HAZ_STAGES-1:0][RID_W-1:0] chk_m;
  logic                           hazard;
  logic                           d_valid;

  always_comb begin
    fetch_w       = STAGE_BUBBLE;
    fetch_w.valid = 1'b1;
    fetch_w.op    = in_op;
    fetch_w.src_a = in_src_a;
    fetch_w.src_b = in_src_b;
    fetch_w.dst_e = in_dst_e;
    fetch_w.dst_m = in_dst_m;
    fetch_w.tag   = in_tag;
  end

  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stg_d[i] = fetch_w;
    end else begin : g_next
      assign stg_d[i] = stg_q[i-1];
    end
    hz_pipe_reg #(.W(SW), .NOP_VAL(STAGE_BUBBLE)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .stall  (st_stall[i]),
      .bubble (st_bubble[i]),
      .d      (stg_d[i]),
      .q      (stg_q[i])
    );
  end

  for (genvar j = 0; j < HAZ_STAGES; j++) begin : g_chk
    assign chk_e[j] = stg_q[j+1].dst_e;
    assign chk_m[j] = stg_q[j+1].dst_m;
  end

  hz_detect #(.N(HAZ_STAGES)) u_det (
    .src_a  (stg_q[0].src_a),
    .src_b  (stg_q[0].src_b),
    .dst_e  (chk_e),
    .dst_m  (chk_m),
    .hazard (hazard)
  );

  hz_mode_ctl #(.NSTG(NSTG)) u_mode (
    .hazard   (hazard),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .stall_f  (stall_f),
    .stall    (st_stall),
    .bubble   (st_bubble)
  );

  assign stall_d  = st_stall[0];
  assign bubble_d = st_bubble[0];
  assign bubble_e = st_bubble[1];
  assign d_valid  = stg_q[0].valid;
  assign ex_valid = stg_q[1].valid;
  assign ex_tag   = stg_q[1].tag;
  assign wb_valid = stg_q[NSTG-1].valid;
  assign wb_op    = stg_q[NSTG-1].op;
  assign wb_dst_e = stg_q[NSTG-1].dst_e;
  assign wb_dst_m = stg_q[NSTG-1].dst_m;
  assign wb_tag   = stg_q[NSTG-1].tag;
endmodule

// File: rtl/hz_stall_ctrl_chk.sv
module hz_stall_ctrl_chk import hz_pkg::*; #(
  parameter int unsigned MAX_STALL = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             stall_f,
  input logic             stall_d,
  input logic             bubble_d,
  input logic             bubble_e,
  input logic             d_valid,
  input logic             ex_valid,
  input logic             wb_valid,
  input logic [OP_W-1:0]  wb_op,
  input logic [RID_W-1:0] wb_dst_e,
  input logic [RID_W-1:0] wb_dst_m
);
  logic [7:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run <= '0;
    else if (stall_d) run <= run + 8'd1;
    else              run <= '0;
  end

  assert_mode_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall_d && bubble_d));

  assert_stall_modes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_d |-> (stall_f && bubble_e && !in_ready));

  assert_ex_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_d |=> !ex_valid);

  assert_idle_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !d_valid);

  assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> d_valid);

  assert_wb_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |-> (wb_op == OP_NOP && wb_dst_e == RID_NONE && wb_dst_m == RID_NONE));

  assert_stall_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_d |-> (run < 8'(MAX_STALL)));
endmodule

bind hz_stall_ctrl hz_stall_ctrl_chk #(.MAX_STALL(HAZ_STAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .stall_f  (stall_f),
  .stall_d  (stall_d),
  .bubble_d (bubble_d),
  .bubble_e (bubble_e),
  .d_valid  (d_valid),
  .ex_valid (ex_valid),
  .wb_valid (wb_valid),
  .wb_op    (wb_op),
  .wb_dst_e (wb_dst_e),
  .wb_dst_m (wb_dst_m)
);

// File: tb/hz_stall_ctrl_test.sv
`timescale 1ns/1ps
module hz_stall_ctrl_test;
  localparam logic [3:0] NO = 4'hF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = 4'h0;
  logic [3:0] in_src_a = NO;
  logic [3:0] in_src_b = NO;
  logic [3:0] in_dst_e = NO;
  logic [3:0] in_dst_m = NO;
  logic [7:0] in_tag = 8'h0;
  logic       stall_f, stall_d, bubble_d, bubble_e, ex_valid, wb_valid;
  logic [7:0] ex_tag, wb_tag;
  logic [3:0] wb_op, wb_dst_e, wb_dst_m;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int stall_cnt = 0;
  int wb_n   = 0;
  int wb_tags [64];
  int wb_cyc  [64];
  int acc_edge = 0;

  always #2.5 clk = ~clk;

  hz_stall_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_dst_e(in_dst_e), .in_dst_m(in_dst_m), .in_tag(in_tag),
    .stall_f(stall_f), .stall_d(stall_d), .bubble_d(bubble_d), .bubble_e(bubble_e),
    .ex_valid(ex_valid), .ex_tag(ex_tag), .wb_valid(wb_valid), .wb_op(wb_op),
    .wb_dst_e(wb_dst_e), .wb_dst_m(wb_dst_m), .wb_tag(wb_tag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_d) stall_cnt = stall_cnt + 1;
      if (wb_valid && wb_n < 64) begin
        wb_tags[wb_n] = int'(wb_tag);
        wb_cyc[wb_n]  = cyc;
        wb_n = wb_n + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] sa, input logic [3:0] sb,
                       input logic [3:0] de, input logic [3:0] dm, input logic [7:0] tg);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src_a = sa; in_src_b = sb;
    in_dst_e = de; in_dst_m = dm; in_tag = tg;
    while (!in_ready) @(negedge clk);
    acc_edge = cyc + 1;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  // R8: reset state
  task automatic t_reset();
    @(negedge clk);
    check(in_ready == 1'b1, "R8 in_ready", int'(in_ready), 1);
    check(stall_d == 1'b0 && ex_valid == 1'b0, "R8 stall/ex", int'({stall_d, ex_valid}), 0);
    check(wb_valid == 1'b0, "R8 wb_valid", int'(wb_valid), 0);
  endtask

  // R1 / R4: producer-consumer distance sets the stall count
  task automatic t_gap(input int g, input bit use_m, input int exp_st);
    int s0, w0;
    logic [7:0] tp, tc;
    s0 = stall_cnt; w0 = wb_n;
    tp = 8'(8'h20 + 2 * g + int'(use_m) * 16);
    tc = tp + 8'd1;
    issue(4'h3, NO, NO, use_m ? NO : 4'h2, use_m ? 4'h2 : NO, tp);
    if (g > 0) idle(g);
    issue(4'h5, use_m ? NO : 4'h2, use_m ? 4'h2 : NO, 4'h4, NO, tc);
    idle(10);
    check(stall_cnt - s0 == exp_st, use_m ? "R1 R4 dstM/srcB stall cycles" : "R1 R4 dstE/srcA stall cycles",
          stall_cnt - s0, exp_st);
    check(wb_n - w0 == 2, "R5 retire count", wb_n - w0, 2);
    check(wb_tags[w0] == int'(tp) && wb_tags[w0+1] == int'(tc), "R5 retire order",
          wb_tags[w0+1], int'(tc));
    check(wb_cyc[w0+1] - wb_cyc[w0] == g + 1 + exp_st, "R4 retire spacing",
          wb_cyc[w0+1] - wb_cyc[w0], g + 1 + exp_st);
  endtask

  // R3: stall holds decode and inserts bubble into execute
  task automatic t_hold();
    int s0, guard;
    s0 = stall_cnt;
    issue(4'h3, NO, NO, NO, 4'h6, 8'h50);
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'h7; in_src_a = NO; in_src_b = 4'h6;
    in_dst_e = 4'h1; in_dst_m = NO; in_tag = 8'h51;
    check(in_ready == 1'b1, "R3 ready before stall", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(stall_d && stall_f && bubble_e && !in_ready, "R3 modes during stall",
          int'({stall_d, stall_f, bubble_e, in_ready}), 14);
    @(negedge clk);
    check(ex_valid == 1'b0, "R3 bubble in execute", int'(ex_valid), 0);
    guard = 0;
    while (!(ex_valid && ex_tag == 8'h51) && guard < 10) begin
      @(negedge clk); guard++;
    end
    check(ex_tag == 8'h51 && ex_valid, "R3 held instruction reaches execute", int'(ex_tag), 8'h51);
    idle(8);
    check(stall_cnt - s0 == 3, "R3 stall length", stall_cnt - s0, 3);
  endtask

  // R2: 4'hF never matches
  task automatic t_none();
    int s0;
    s0 = stall_cnt;
    issue(4'h3, NO, NO, NO, NO, 8'h60);
    issue(4'h3, NO, NO, 4'h3, NO, 8'h61);
    issue(4'h5, NO, 4'h5, NO, NO, 8'h62);
    issue(4'h5, NO, NO, NO, NO, 8'h63);
    idle(8);
    check(stall_cnt == s0, "R2 no-register ID never stalls", stall_cnt - s0, 0);
  endtask

  // R1: two producers in flight, consumer reads both
  task automatic t_two();
    int s0;
    s0 = stall_cnt;
    issue(4'h3, NO, NO, 4'h1, NO, 8'h70);
    issue(4'h4, NO, NO, NO, 4'h2, 8'h71);
    issue(4'h5, 4'h1, 4'h2, NO, NO, 8'h72);
    idle(10);
    check(stall_cnt - s0 == 3, "R1 two producers", stall_cnt - s0, 3);
  endtask

  // R5: independent stream, latency and order
  task automatic t_stream();
    int s0, w0, a0, ok;
    s0 = stall_cnt; w0 = wb_n;
    issue(4'h2, 4'h7, NO, 4'h0, NO, 8'h40);
    a0 = acc_edge;
    for (int i = 1; i < 5; i++) issue(4'h2, 4'h7, NO, 4'(i), NO, 8'(8'h40 + i));
    idle(8);
    check(stall_cnt == s0, "R5 stream no stall", stall_cnt - s0, 0);
    check(wb_n - w0 == 5, "R5 stream count", wb_n - w0, 5);
    check(wb_cyc[w0] == a0 + 3, "R5 latency", wb_cyc[w0] - a0, 3);
    ok = 1;
    for (int i = 0; i < 5; i++)
      if (wb_tags[w0+i] != 8'h40 + i || wb_cyc[w0+i] != wb_cyc[w0] + i) ok = 0;
    check(ok == 1, "R5 stream order back to back", ok, 1);
  endtask

  // R6 / R7: fields on an idle slot are ignored; empty write-back is a no-op
  task automatic t_idle_fields();
    int s0, w0;
    s0 = stall_cnt; w0 = wb_n;
    @(negedge clk);
    in_valid = 1'b0; in_op = 4'h3; in_dst_e = 4'h2; in_dst_m = 4'h2; in_tag = 8'h80;
    @(posedge clk);
    issue(4'h5, 4'h2, 4'h2, NO, NO, 8'h81);
    idle(8);
    check(stall_cnt == s0, "R6 idle fields cause no stall", stall_cnt - s0, 0);
    check(wb_n - w0 == 1 && wb_tags[w0] == 8'h81, "R6 only real instruction retires",
          wb_n - w0, 1);
    @(negedge clk);
    check(!wb_valid && wb_op == 4'h0 && wb_dst_e == NO && wb_dst_m == NO,
          "R7 empty write-back pattern", int'({wb_op, wb_dst_e, wb_dst_m}), 12'h0FF);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_gap(0, 1'b0, 3);
    t_gap(1, 1'b0, 2);
    t_gap(2, 1'b1, 1);
    t_gap(3, 1'b0, 0);
    t_gap(0, 1'b1, 3);
    t_gap(4, 1'b1, 0);
    t_hold();
    t_none();
    t_two();
    t_stream();
    t_idle_fields();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule